// File: doc/BRIEF.md
# DMA Descriptor Chain Walker

This block drives one DMA channel through a multi-buffer transfer whose buffers are described by a linked chain of descriptors held in memory. Software programs the channel's registers through a small write port and then pulses `start`. When control register B has both reload flags clear, the block walks the chain. It reads a five-word descriptor from the address in the head pointer and overwrites the channel registers with the fetched words. It then hands the buffer to a data mover through a start/done handshake. When the mover finishes, the block moves the fetched next pointer into the head pointer and goes on to the next descriptor. A zero next pointer ends the chain.

If either reload flag is set at start, the block runs exactly one buffer with the registers as software left them and reads nothing from memory. A misaligned descriptor address raises an error flag and stops the channel. A disable request is honoured only at a buffer boundary, so a descriptor is never left partly loaded.

Top module: `dma_chain_walker`

## Requirements
- R1: A descriptor occupies five 32-bit words. Offset 0x0 holds the source address, 0x4 the destination address, 0x8 control A, 0xC control B and 0x10 the next pointer. The block reads them at head, head+4, ... head+0x10 in that order, with at most one read outstanding.
- R2: Software writes `sw_data` into the register chosen by `sw_sel` (0 source, 1 destination, 2 control A, 3 control B, 4 head pointer). A `start` pulse while idle begins a chain walk when control B bits 0 and 1 are both zero.
- R3: Fetched descriptor words replace whatever software wrote in the source, destination, control A and control B registers.
- R4: Once a descriptor is fully loaded, `mv_start` pulses for one cycle. The block then waits for `mv_done`.
- R5: On `mv_done` during a chain walk, `buf_done` pulses for one cycle and the head pointer takes the fetched next pointer.
- R6: When the next pointer is zero, `chain_done` pulses together with `buf_done` and `busy` falls. No further reads are issued.
- R7: When the next pointer is non-zero, the following descriptor is fetched from that address.
- R8: A start with a head pointer whose bits 1:0 are non-zero sets `align_err`, issues no read and leaves `busy` low. A misaligned non-zero next pointer sets `align_err` after the current buffer and ends the walk without `chain_done`. The next start clears `align_err`.
- R9: A `disable_req` pulse while busy lets the current descriptor and buffer finish, then stops the channel with no further fetch and no `chain_done`.
- R10: If control B bit 0 or bit 1 is set at start, one `mv_start` is issued with the programmed registers and no memory read. On `mv_done`, both `buf_done` and `chain_done` pulse and the head pointer is unchanged.
- R11: While `busy` is high, software writes and `start` pulses are ignored.
- R12: Once `rd_req_valid` is raised, it stays high with `rd_req_addr` unchanged until `rd_req_ready` accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select for software write |
| sw_data | input | 32 | Software write data |
| start | input | 1 | Start the channel (pulse) |
| disable_req | input | 1 | Stop at next buffer boundary (pulse) |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response data |
| mv_start | output | 1 | Data mover start pulse |
| mv_done | input | 1 | Data mover finished the buffer |
| src_addr | output | 32 | Source address register |
| dst_addr | output | 32 | Destination address register |
| ctrl_a | output | 32 | Control A register |
| ctrl_b | output | 32 | Control B register |
| head_ptr | output | 32 | Head (descriptor) pointer register |
| busy | output | 1 | Channel active |
| buf_done | output | 1 | One-cycle pulse per finished buffer |
| chain_done | output | 1 | One-cycle pulse when the last buffer finishes |
| align_err | output | 1 | Misaligned descriptor address seen |

## Verification
The hardest situations to reach are the ones that arise mid-walk. One is a disable request that arrives while a fetch is half done. Another is a start or register write landing in the middle of a running chain. A third is a misaligned pointer that turns up only as the next pointer of a fetched descriptor rather than in the programmed head. The bench builds each case with chains laid out in its memory model: one descriptor's next field is set to an unaligned value, and the disable, start and write pulses are timed to fall inside the first fetch. The main walk is also swept over chain lengths, request-ready delays, response latencies and mover latencies, so that every stall point in the handshakes is hit.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int SEL_W      = 3;
    localparam int ALIGN_BITS = 2;

    // descriptor word order is fixed by the memory layout
    localparam logic [IDX_W-1:0] W_SRC  = 3'd0;
    localparam logic [IDX_W-1:0] W_DST  = 3'd1;
    localparam logic [IDX_W-1:0] W_CA   = 3'd2;
    localparam logic [IDX_W-1:0] W_CB   = 3'd3;
    localparam logic [IDX_W-1:0] W_NEXT = 3'd4;

    // software select codes
    localparam logic [SEL_W-1:0] SEL_SRC  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DST  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CA   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CB   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_HEAD = 3'd4;

    // control B reload flags
    localparam int CB_SRC_RELOAD = 0;
    localparam int CB_DST_RELOAD = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_WAIT
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] ctla;
        logic [WORD_W-1:0] ctlb;
        logic [WORD_W-1:0] head;
        logic [WORD_W-1:0] next;
    } chan_regs_t;

    function automatic logic addr_aligned(input logic [WORD_W-1:0] a);
        return a[ALIGN_BITS-1:0] == '0;
    endfunction

    function automatic logic reload_mode(input logic [WORD_W-1:0] cb);
        return cb[CB_SRC_RELOAD] | cb[CB_DST_RELOAD];
    endfunction

    function automatic logic [WORD_W-1:0] word_offset(input logic [IDX_W-1:0] idx);
        return WORD_W'(idx) << ALIGN_BITS;
    endfunction

endpackage

// File: rtl/dmaw_fetch.sv
module dmaw_fetch
    import dmaw_pkg::*;
#(
    parameter int N_WORDS = DESC_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] base,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [WORD_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    output logic              ld_en,
    output logic [IDX_W-1:0]  ld_idx,
    output logic              fetch_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    logic             active;
    logic             pend;
    logic [IDX_W-1:0] idx;

    assign rd_req_valid = active && !pend;
    assign rd_req_addr  = base + word_offset(idx);
    assign ld_en        = active && pend && rd_rsp_valid;
    assign ld_idx       = idx;
    assign fetch_done   = ld_en && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pend   <= 1'b0;
            idx    <= '0;
        end else if (go) begin
            active <= 1'b1;
            pend   <= 1'b0;
            idx    <= '0;
        end else if (active) begin
            if (rd_req_valid && rd_req_ready) begin
                pend <= 1'b1;
            end
            if (ld_en) begin
                pend <= 1'b0;
                idx  <= idx + 1'b1;
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dmaw_regs.sv
module dmaw_regs
    import dmaw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [SEL_W-1:0]  sw_sel,
    input  logic [WORD_W-1:0] sw_data,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              adv_head,
    output chan_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (sw_we) begin
                case (sw_sel)
                    SEL_SRC:  regs.src  <= sw_data;
                    SEL_DST:  regs.dst  <= sw_data;
                    SEL_CA:   regs.ctla <= sw_data;
                    SEL_CB:   regs.ctlb <= sw_data;
                    SEL_HEAD: regs.head <= sw_data;
                    default:  ;
                endcase
            end
            if (ld_en) begin
                case (ld_idx)
                    W_SRC:   regs.src  <= ld_data;
                    W_DST:   regs.dst  <= ld_data;
                    W_CA:    regs.ctla <= ld_data;
                    W_CB:    regs.ctlb <= ld_data;
                    W_NEXT:  regs.next <= ld_data;
                    default: ;
                endcase
            end
            if (adv_head) begin
                regs.head <= regs.next;
            end
        end
    end

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dmaw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [2:0]        sw_sel,
    input  logic [31:0]       sw_data,
    input  logic              start,
    input  logic              disable_req,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [31:0]       rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              mv_start,
    input  logic              mv_done,
    output logic [31:0]       src_addr,
    output logic [31:0]       dst_addr,
    output logic [31:0]       ctrl_a,
    output logic [31:0]       ctrl_b,
    output logic [31:0]       head_ptr,
    output logic              busy,
    output logic              buf_done,
    output logic              chain_done,
    output logic              align_err
);
    walk_state_t state;
    chan_regs_t  regs;
    logic        single_q;
    logic        dis_pend;
    logic        go_fetch;
    logic        adv_head;
    logic        ld_en;
    logic [IDX_W-1:0] ld_idx;
    logic        fetch_done;
    logic        idle;
    logic        take_start;
    logic        buf_end;

    assign idle       = (state == ST_IDLE);
    assign take_start = idle && start;
    assign buf_end    = (state == ST_WAIT) && mv_done;
    assign adv_head   = buf_end && !single_q;

    // fetch begins on an accepted linked start or after a buffer with more to do
    always_comb begin
        go_fetch = 1'b0;
        if (take_start && !reload_mode(regs.ctlb) && addr_aligned(regs.head)) begin
            go_fetch = 1'b1;
        end else if (buf_end && !single_q && regs.next != '0 && !dis_pend
                     && addr_aligned(regs.next)) begin
            go_fetch = 1'b1;
        end
    end

    dmaw_fetch #(.N_WORDS(DESC_WORDS)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .go           (go_fetch),
        .base         (regs.head),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .ld_en        (ld_en),
        .ld_idx       (ld_idx),
        .fetch_done   (fetch_done)
    );

    dmaw_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we && idle),
        .sw_sel   (sw_sel),
        .sw_data  (sw_data),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_data  (rd_rsp_data),
        .adv_head (adv_head),
        .regs     (regs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            single_q   <= 1'b0;
            dis_pend   <= 1'b0;
            align_err  <= 1'b0;
            buf_done   <= 1'b0;
            chain_done <= 1'b0;
        end else begin
            buf_done   <= 1'b0;
            chain_done <= 1'b0;
            if (!idle && disable_req) begin
                dis_pend <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    dis_pend <= 1'b0;
                    if (start) begin
                        align_err <= 1'b0;
                        if (reload_mode(regs.ctlb)) begin
                            single_q <= 1'b1;
                            state    <= ST_MOVE;
                        end else if (!addr_aligned(regs.head)) begin
                            align_err <= 1'b1;
                        end else begin
                            single_q <= 1'b0;
                            state    <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        state <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mv_done) begin
                        buf_done <= 1'b1;
                        if (single_q || regs.next == '0) begin
                            chain_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else if (go_fetch) begin
                            state <= ST_FETCH;
                        end else begin
                            if (!dis_pend) begin
                                align_err <= 1'b1;
                            end
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mv_start = (state == ST_MOVE);
    assign busy     = !idle;
    assign src_addr = regs.src;
    assign dst_addr = regs.dst;
    assign ctrl_a   = regs.ctla;
    assign ctrl_b   = regs.ctlb;
    assign head_ptr = regs.head;

endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_req_valid,
    input logic        rd_req_ready,
    input logic [31:0] rd_req_addr,
    input logic        mv_start,
    input logic        busy,
    input logic        buf_done,
    input logic        chain_done,
    input logic        align_err
);
    // R1: reads only while the channel is walking
    p_read_when_busy_r1: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> busy);

    // R8: every issued read address is word aligned
    p_read_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_addr[1:0] == 2'b00);

    // R12: a stalled request holds its address
    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R4: mover start is a single-cycle pulse
    p_mv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);

    // R5: buffer completion is a single-cycle pulse
    p_buf_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        buf_done |=> !buf_done);

    // R6: chain completion coincides with the last buffer and an idle channel
    p_chain_with_buf_r6: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> buf_done && !busy);

    // R8: a newly raised error always leaves the channel idle
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(align_err) |-> !busy);

endmodule

bind dma_chain_walker dmaw_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .mv_start     (mv_start),
    .busy         (busy),
    .buf_done     (buf_done),
    .chain_done   (chain_done),
    .align_err    (align_err)
);

// File: tb/sim_dma_chain_walker.sv
module sim_dma_chain_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_sel = '0;
    logic [31:0] sw_data = '0;
    logic        start = 1'b0;
    logic        disable_req = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        mv_start;
    logic        mv_done = 1'b0;
    logic [31:0] src_addr, dst_addr, ctrl_a, ctrl_b, head_ptr;
    logic        busy, buf_done, chain_done, align_err;

    always #4 clk = ~clk;

    dma_chain_walker u0 (.*);

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] mem [0:255];
    logic [31:0] exp_addr [0:39];
    logic [31:0] exp_src [0:7];
    logic [31:0] exp_dst [0:7];
    logic [31:0] exp_ca [0:7];
    logic [31:0] exp_cb [0:7];
    logic [31:0] exp_next [0:7];

    int rdy_dly = 0, rsp_lat = 1, mv_lat = 1;
    int reads = 0, starts = 0, bufs = 0, chains = 0, cur = 0;
    bit chk_regs = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder
    bit          pend = 1'b0;
    int          lat_cnt = 0, wait_cnt = 0;
    logic [31:0] pend_addr = '0;
    logic        last_valid = 1'b0;
    logic [31:0] last_addr = '0;
    always @(negedge clk) begin
        rd_rsp_valid = 1'b0;
        if (rst) begin
            pend = 1'b0; rd_req_ready = 1'b0; last_valid = 1'b0; wait_cnt = 0;
        end else begin
            if (rd_req_ready && last_valid) begin
                if (reads < 40) check("R1 read address order", last_addr, exp_addr[reads]);
                reads++;
                pend = 1'b1; pend_addr = last_addr; lat_cnt = rsp_lat;
                rd_req_ready = 1'b0;
            end else begin
                if (last_valid && rd_req_valid)
                    check("R12 stalled address stable", rd_req_addr, last_addr);
                if (pend) begin
                    if (lat_cnt <= 1) begin
                        rd_rsp_valid = 1'b1;
                        rd_rsp_data  = mem[pend_addr[9:2]];
                        pend = 1'b0;
                    end else lat_cnt--;
                end
            end
            if (rd_req_valid && !pend && !rd_req_ready) begin
                if (wait_cnt >= rdy_dly) begin rd_req_ready = 1'b1; wait_cnt = 0; end
                else wait_cnt++;
            end
            last_valid = rd_req_valid;
            last_addr  = rd_req_addr;
        end
    end

    // data mover model and completion monitor
    bit mv_busy = 1'b0;
    int mv_cnt = 0;
    always @(negedge clk) begin
        mv_done = 1'b0;
        if (!rst) begin
            if (mv_busy) begin
                if (mv_cnt <= 1) begin mv_done = 1'b1; mv_busy = 1'b0; end
                else mv_cnt--;
            end
            if (mv_start) begin
                starts++;
                mv_busy = 1'b1; mv_cnt = mv_lat;
                if (chk_regs && cur < 8) begin
                    check("R3 source loaded", src_addr, exp_src[cur]);
                    check("R3 destination loaded", dst_addr, exp_dst[cur]);
                    check("R3 control A loaded", ctrl_a, exp_ca[cur]);
                    check("R3 control B loaded", ctrl_b, exp_cb[cur]);
                end
            end
            if (buf_done) begin
                bufs++;
                if (chk_regs && cur < 8) check("R5 head takes next", head_ptr, exp_next[cur]);
                cur++;
            end
            if (chain_done) chains++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); sw_we = 1'b1; sw_sel = sel; sw_data = d;
        @(negedge clk); sw_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin @(negedge clk); n++; end
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(posedge clk); #1;
        reads = 0; starts = 0; bufs = 0; chains = 0; cur = 0;
    endtask

    // lay out a chain of len descriptors; bad_next puts a misaligned pointer in descriptor 0
    task automatic build_chain(input int len, input int tag, input bit bad_next);
        for (int k = 0; k < len; k++) begin
            logic [31:0] b;
            b = 32'h40 + 32'(k) * 32'h20;
            exp_src[k]  = 32'h1000_0000 + 32'(k) * 32'h100 + 32'(tag);
            exp_dst[k]  = 32'h2000_0000 + 32'(k) * 32'h100 + 32'(tag);
            exp_ca[k]   = 32'hA000_0000 + 32'(k);
            exp_cb[k]   = 32'hC000_0003 | (32'(k) << 4);
            exp_next[k] = (k == len - 1) ? 32'h0 : b + 32'h20;
            if (bad_next && k == 0) exp_next[k] = 32'h66;
            mem[b[9:2] + 0] = exp_src[k];
            mem[b[9:2] + 1] = exp_dst[k];
            mem[b[9:2] + 2] = exp_ca[k];
            mem[b[9:2] + 3] = exp_cb[k];
            mem[b[9:2] + 4] = exp_next[k];
            for (int w = 0; w < 5; w++) exp_addr[k * 5 + w] = b + 32'(w) * 4;
        end
    endtask

    task automatic program_linked(input logic [31:0] head);
        sw_write(3'd0, 32'hDEAD_0000);
        sw_write(3'd1, 32'hDEAD_1111);
        sw_write(3'd2, 32'hDEAD_2222);
        sw_write(3'd3, 32'h0);
        sw_write(3'd4, head);
    endtask

    task automatic run_chain(input int len, input int rd, input int lt, input int ml, input bit poke);
        rdy_dly = rd; rsp_lat = lt; mv_lat = ml;
        build_chain(len, rd * 16 + lt * 4 + ml, 1'b0);
        program_linked(32'h40);
        clear_counts();
        chk_regs = 1'b1;
        pulse_start();
        if (poke) begin
            // R11: write and restart attempts while busy have no effect
            sw_write(3'd4, 32'h300);
            pulse_start();
        end
        wait_idle();
        check("R2 R7 reads for whole chain", 32'(reads), 32'(len * 5));
        check("R4 one mover start per buffer", 32'(starts), 32'(len));
        check("R5 buffers completed", 32'(bufs), 32'(len));
        check("R6 one chain completion", 32'(chains), 32'd1);
        check("R6 head zero at end", head_ptr, 32'h0);
        check("R6 idle after chain", {31'b0, busy}, 32'd0);
        if (poke) check("R11 restart while busy ignored", 32'(reads), 32'(len * 5));
        chk_regs = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset busy", {31'b0, busy}, 32'd0);
        check("R1 reset no read", {31'b0, rd_req_valid}, 32'd0);
        check("R4 reset no mover start", {31'b0, mv_start}, 32'd0);
        check("R8 reset error clear", {31'b0, align_err}, 32'd0);
        check("R2 reset head", head_ptr, 32'h0);

        // sweep chain length and handshake timing
        for (int len = 1; len <= 4; len++)
            for (int rd = 0; rd < 3; rd++)
                for (int lt = 1; lt <= 3; lt++)
                    run_chain(len, rd, lt, (len + rd + lt) % 3 + 1, 1'b0);

        // R11: pokes during a running chain
        run_chain(3, 1, 2, 2, 1'b1);

        // R8: misaligned head
        program_linked(32'h42);
        clear_counts();
        pulse_start();
        check("R8 misaligned head flags error", {31'b0, align_err}, 32'd1);
        check("R8 misaligned head stays idle", {31'b0, busy}, 32'd0);
        repeat (5) @(negedge clk);
        check("R8 misaligned head no read", 32'(reads), 32'd0);
        // error clears on the next start
        run_chain(1, 0, 1, 1, 1'b0);
        check("R8 error cleared by start", {31'b0, align_err}, 32'd0);

        // R8: misaligned next pointer inside the chain
        rdy_dly = 0; rsp_lat = 1; mv_lat = 2;
        build_chain(2, 7, 1'b1);
        program_linked(32'h40);
        clear_counts();
        pulse_start();
        wait_idle();
        check("R8 bad next one buffer", 32'(bufs), 32'd1);
        check("R8 bad next no chain done", 32'(chains), 32'd0);
        check("R8 bad next flags error", {31'b0, align_err}, 32'd1);
        check("R8 bad next head loaded", head_ptr, 32'h66);
        check("R8 bad next no extra read", 32'(reads), 32'd5);

        // R9: disable during the first fetch
        rdy_dly = 1; rsp_lat = 2; mv_lat = 3;
        build_chain(3, 9, 1'b0);
        program_linked(32'h40);
        clear_counts();
        pulse_start();
        @(negedge clk); disable_req = 1'b1;
        @(negedge clk); disable_req = 1'b0;
        wait_idle();
        check("R9 disable finishes descriptor", 32'(reads), 32'd5);
        check("R9 disable finishes buffer", 32'(bufs), 32'd1);
        check("R9 disable no chain done", 32'(chains), 32'd0);
        check("R9 disable head advanced", head_ptr, 32'h60);
        check("R9 disable idle", {31'b0, busy}, 32'd0);

        // R10: single-buffer mode with each reload flag
        for (int f = 1; f <= 2; f++) begin
            mv_lat = f + 1;
            sw_write(3'd0, 32'h5555_0000 + 32'(f));
            sw_write(3'd1, 32'h6666_0000 + 32'(f));
            sw_write(3'd2, 32'h7777_0000 + 32'(f));
            sw_write(3'd3, 32'(f));
            sw_write(3'd4, 32'h40);
            exp_src[0] = 32'h5555_0000 + 32'(f);
            exp_dst[0] = 32'h6666_0000 + 32'(f);
            exp_ca[0]  = 32'h7777_0000 + 32'(f);
            exp_cb[0]  = 32'(f);
            exp_next[0] = 32'h40;
            clear_counts();
            chk_regs = 1'b1;
            pulse_start();
            wait_idle();
            chk_regs = 1'b0;
            check("R10 single no reads", 32'(reads), 32'd0);
            check("R10 single one mover start", 32'(starts), 32'd1);
            check("R10 single buffer done", 32'(bufs), 32'd1);
            check("R10 single chain done", 32'(chains), 32'd1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule